// File: doc/BRIEF.md
# Block Write Transfer Sequencer

This block sequences a card-side block write for a storage-card host controller. Software loads a start request with a command index, a 32-bit argument, a byte count, a block size and an auto-stop enable, then pulses `go`. The request waits in a holding register until the command channel is free. Once accepted, the command goes to a line engine over a request/done handshake. The data phase then pops bytes from a transmit FIFO towards the line engine and marks the last byte of every block. The FIFO data itself runs straight from the FIFO to the line engine and does not pass through this block.

A byte count of zero gives an open-ended transfer. Blocks keep flowing until software issues a stop command (index 12). A nonzero count must be a whole multiple of the block size. When that count has been sent, the block either issues the stop command itself, if auto-stop is set, or halts and waits for software to send the stop. The response to the self-issued stop goes to its own register. Six sticky interrupt flags report events, and software clears them by writing 1.

Top module: `blkwr_seq`

## Requirements
- R1: A `go` pulse while no request is pending captures all request fields and raises `start_pend` on the next cycle. `start_pend` drops in the cycle after the request is accepted or rejected. A `go` pulse while a request is already pending is ignored.
- R2: An accepted command drives `cmd_req` with steady `cmd_idx`/`cmd_arg` until the cycle in which `cmd_done` is high. For every command that software issued, `cmd_done` copies `cmd_resp` into `resp_main` and sets irq bit 0 (command done).
- R3: A pending request is not accepted while a command is in flight. During the data phase only a stop request (index 12) is accepted. It halts data at once, in the very cycle it is accepted.
- R4: A data request whose block size is zero, or whose byte count is not a multiple of the block size, sets irq bit 5 (error). It is dropped without raising `cmd_req`.
- R5: `fifo_rd` is high only in the data phase and only when `dat_ready` is high and `fifo_empty` is low. `dat_last` is high together with `fifo_rd` on the final byte of each block.
- R6: A nonzero byte count produces exactly that many `fifo_rd` pops.
- R7: With auto-stop set, index 12 with argument 0 is issued after the last byte. Its response goes to `stop_resp`, `resp_main` is left unchanged, and irq bits 1 (auto-command done) and 2 (transfer done) are set.
- R8: With auto-stop clear, no pops follow the last byte, and the block waits for a software stop.
- R9: A byte count of zero pops bytes without limit until a software stop. Completion of a software stop that ends a data transfer sets irq bit 2.
- R10: irq bit 3 (FIFO data request) is set in each data-phase cycle in which `fifo_low` is high.
- R11: irq bit 4 (starvation) is set after STARVE_LIM consecutive data-phase cycles in which `dat_ready` is high and `fifo_empty` is high.
- R12: irq flags are sticky. A 1 in `irq_clr` clears the matching bit, and a new set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe for a new request |
| go_idx | input | IDX_W | Command index |
| go_arg | input | ARG_W | Command argument |
| go_bytes | input | CNT_W | Byte count, 0 = open-ended |
| go_blk | input | CNT_W | Block size in bytes |
| go_auto | input | 1 | Auto-stop enable |
| start_pend | output | 1 | Request waiting for acceptance |
| cmd_req | output | 1 | Command request to the line engine |
| cmd_idx | output | IDX_W | Index of the requested command |
| cmd_arg | output | ARG_W | Argument of the requested command |
| cmd_done | input | 1 | Line engine finished the command |
| cmd_resp | input | RSP_W | Response that comes with `cmd_done` |
| fifo_empty | input | 1 | Transmit FIFO empty |
| fifo_low | input | 1 | Transmit FIFO at or below its watermark |
| fifo_rd | output | 1 | Pop one byte towards the line engine |
| dat_ready | input | 1 | Line engine can take a byte |
| dat_last | output | 1 | Popped byte ends a block |
| irq_clr | input | 6 | Write-1-to-clear for the irq flags |
| irq | output | 6 | Sticky flags: 0 cmd, 1 auto-cmd, 2 xfer, 3 data req, 4 starve, 5 error |
| resp_main | output | RSP_W | Response of the last command software issued |
| stop_resp | output | RSP_W | Response of the last self-issued stop |

## Verification
A wrong sequencer state shows at the ports within one clock. A stale phase either keeps `fifo_rd` alive after the count is reached, or drops `cmd_req` before `cmd_done`. A miscounted block position moves `dat_last` off the final byte of a block. A wrong completion path puts a stop response in the wrong register, or sets the wrong irq bit, on the cycle after `cmd_done`. Because every output is compared with a behavioural model on every cycle, any of these shows up in the first cycle in which it appears.

// File: rtl/blkwr_seq.sv
module blkwr_seq #(
  parameter int IDX_W      = 6,
  parameter int ARG_W      = 32,
  parameter int CNT_W      = 16,
  parameter int RSP_W      = 32,
  parameter int STARVE_LIM = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [IDX_W-1:0] go_idx,
  input  logic [ARG_W-1:0] go_arg,
  input  logic [CNT_W-1:0] go_bytes,
  input  logic [CNT_W-1:0] go_blk,
  input  logic             go_auto,
  output logic             start_pend,
  output logic             cmd_req,
  output logic [IDX_W-1:0] cmd_idx,
  output logic [ARG_W-1:0] cmd_arg,
  input  logic             cmd_done,
  input  logic [RSP_W-1:0] cmd_resp,
  input  logic             fifo_empty,
  input  logic             fifo_low,
  output logic             fifo_rd,
  input  logic             dat_ready,
  output logic             dat_last,
  input  logic [5:0]       irq_clr,
  output logic [5:0]       irq,
  output logic [RSP_W-1:0] resp_main,
  output logic [RSP_W-1:0] stop_resp
);
  localparam int SC_W = $clog2(STARVE_LIM + 1);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(12);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [SC_W-1:0]  SC_TOP = SC_W'(STARVE_LIM - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_HOLD, S_ASTOP, S_SSTOP, S_SOLO} st_t;
  st_t st;

  logic             pend, p_auto, fixed, autos;
  logic [IDX_W-1:0] p_idx, c_idx;
  logic [ARG_W-1:0] p_arg, c_arg;
  logic [CNT_W-1:0] p_bytes, p_blk, left, blk_sz, blk_pos;
  logic [SC_W-1:0]  scnt;
  logic [5:0]       set;

  wire p_stop    = p_idx == STOP_IDX;
  wire fits      = (p_blk != '0) && ((p_bytes % p_blk) == '0);
  wire in_data   = (st == S_DATA) || (st == S_HOLD);
  wire take_new  = pend && st == S_IDLE && (p_stop || fits);
  wire take_stop = pend && in_data && p_stop;
  wire reject    = pend && st == S_IDLE && !p_stop && !fits;
  wire xfer      = st == S_DATA && !take_stop && dat_ready && !fifo_empty;
  wire last_byte = fixed && left == ONE;
  wire starving  = st == S_DATA && dat_ready && fifo_empty;
  wire done      = cmd_req && cmd_done;

  assign start_pend = pend;
  assign cmd_req  = st == S_CMD || st == S_ASTOP || st == S_SSTOP || st == S_SOLO;
  assign cmd_idx  = st == S_ASTOP ? STOP_IDX : c_idx;
  assign cmd_arg  = st == S_ASTOP ? '0 : c_arg;
  assign fifo_rd  = xfer;
  assign dat_last = xfer && blk_pos == blk_sz - ONE;

  always_comb begin
    set    = '0;
    set[0] = done && st != S_ASTOP;
    set[1] = done && st == S_ASTOP;
    set[2] = done && (st == S_ASTOP || st == S_SSTOP);
    set[3] = st == S_DATA && fifo_low;
    set[4] = starving && scnt == SC_TOP;
    set[5] = reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= '0;
      scnt      <= '0;
      resp_main <= '0;
      stop_resp <= '0;
    end else begin
      irq  <= (irq & ~irq_clr) | set;
      scnt <= starving ? ((scnt == SC_TOP) ? '0 : scnt + 1'b1) : '0;
      if (done && st != S_ASTOP) resp_main <= cmd_resp;
      if (done && st == S_ASTOP) stop_resp <= cmd_resp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      p_idx   <= '0;
      p_arg   <= '0;
      p_bytes <= '0;
      p_blk   <= '0;
      p_auto  <= 1'b0;
    end else if (take_new || take_stop || reject) begin
      pend <= 1'b0;
    end else if (go && !pend) begin
      pend    <= 1'b1;
      p_idx   <= go_idx;
      p_arg   <= go_arg;
      p_bytes <= go_bytes;
      p_blk   <= go_blk;
      p_auto  <= go_auto;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      c_idx   <= '0;
      c_arg   <= '0;
      left    <= '0;
      blk_sz  <= '0;
      blk_pos <= '0;
      fixed   <= 1'b0;
      autos   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take_new) begin
          c_idx   <= p_idx;
          c_arg   <= p_arg;
          left    <= p_bytes;
          fixed   <= p_bytes != '0;
          autos   <= p_auto;
          blk_sz  <= p_blk;
          blk_pos <= '0;
          st      <= p_stop ? S_SOLO : S_CMD;
        end
        S_CMD: if (done) st <= S_DATA;
        S_DATA, S_HOLD: begin
          if (take_stop) begin
            c_idx <= p_idx;
            c_arg <= p_arg;
            st    <= S_SSTOP;
          end else if (xfer) begin
            blk_pos <= (blk_pos == blk_sz - ONE) ? '0 : blk_pos + ONE;
            if (fixed) left <= left - ONE;
            if (last_byte) st <= autos ? S_ASTOP : S_HOLD;
          end
        end
        S_ASTOP, S_SSTOP, S_SOLO: if (done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkwr_seq_chk.sv
module blkwr_seq_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_req,
  input logic             cmd_done,
  input logic [IDX_W-1:0] cmd_idx,
  input logic             fifo_rd,
  input logic             fifo_empty,
  input logic             dat_ready,
  input logic             dat_last,
  input logic [5:0]       irq,
  input logic [5:0]       irq_clr
);
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_done |=> cmd_req && $stable(cmd_idx)); // R2
  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> dat_ready && !fifo_empty); // R5
  AST_LAST_WITH_RD: assert property (@(posedge clk) disable iff (!rst_n)
    dat_last |-> fifo_rd); // R5
  AST_AUTO_IS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[1]) |-> $past(cmd_req) && $past(cmd_idx) == IDX_W'(12)); // R7
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq) & ~$past(irq_clr)) & ~irq) == 6'd0); // R12
endmodule

bind blkwr_seq blkwr_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_done(cmd_done),
  .cmd_idx(cmd_idx), .fifo_rd(fifo_rd), .fifo_empty(fifo_empty),
  .dat_ready(dat_ready), .dat_last(dat_last), .irq(irq), .irq_clr(irq_clr)
);

// File: tb/blkwr_seq_tb_top.sv
module blkwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 16;

  logic clk = 0, rst_n = 0, go = 0, go_auto = 0;
  logic [5:0] go_idx = 0;
  logic [31:0] go_arg = 0;
  logic [15:0] go_bytes = 0, go_blk = 0;
  logic start_pend, cmd_req, fifo_rd, dat_last;
  logic [5:0] cmd_idx, irq, irq_clr = 0;
  logic [31:0] cmd_arg, resp_main, stop_resp;
  logic cmd_done = 0, fifo_empty = 0, fifo_low = 0, dat_ready = 1;
  logic [31:0] cmd_resp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkwr_seq #(.STARVE_LIM(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .go_idx(go_idx), .go_arg(go_arg),
    .go_bytes(go_bytes), .go_blk(go_blk), .go_auto(go_auto), .start_pend(start_pend),
    .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_done(cmd_done),
    .cmd_resp(cmd_resp), .fifo_empty(fifo_empty), .fifo_low(fifo_low), .fifo_rd(fifo_rd),
    .dat_ready(dat_ready), .dat_last(dat_last), .irq_clr(irq_clr), .irq(irq),
    .resp_main(resp_main), .stop_resp(stop_resp));

  int n_chk = 0, n_fail = 0, cyc = 0, lat = 0, rcount = 0, d_pops = 0, fe_mode = 0;
  logic [31:0] last_resp = 0;

  // behavioural reference: 0 idle,1 cmd,2 data,3 hold,4 auto stop,5 sw stop,6 lone cmd
  int m_st = 0, mp_bytes = 0, mp_blk = 0, m_left = 0, m_blk = 0, m_pos = 0, m_scnt = 0;
  bit m_pend = 0, mp_auto = 0, m_fixed = 0, m_auto = 0;
  logic [5:0] mp_idx = 0, mc_idx = 0, m_irq = 0, nirq;
  logic [31:0] mp_arg = 0, mc_arg = 0, m_resp = 0, m_sresp = 0;
  bit mx_req, mx_done, mx_stopP, mx_fits, mx_new, mx_stop, mx_rej, mx_xfer, mx_last;

  always @* begin
    mx_req   = (m_st == 1) || (m_st >= 4);
    mx_done  = mx_req && cmd_done;
    mx_stopP = mp_idx == 6'd12;
    mx_fits  = (mp_blk != 0) ? ((mp_bytes % mp_blk) == 0) : 1'b0;
    mx_new   = m_pend && m_st == 0 && (mx_stopP || mx_fits);
    mx_stop  = m_pend && (m_st == 2 || m_st == 3) && mx_stopP;
    mx_rej   = m_pend && m_st == 0 && !mx_stopP && !mx_fits;
    mx_xfer  = m_st == 2 && !mx_stop && dat_ready && !fifo_empty;
    mx_last  = mx_xfer && (m_pos == m_blk - 1);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_irq = 0; m_scnt = 0; m_resp = 0; m_sresp = 0;
    end else begin
      nirq = m_irq & ~irq_clr;
      if (mx_done && m_st != 4) begin nirq[0] = 1; m_resp = cmd_resp; end
      if (mx_done && m_st == 4) begin nirq[1] = 1; m_sresp = cmd_resp; end
      if (mx_done && (m_st == 4 || m_st == 5)) nirq[2] = 1;
      if (m_st == 2 && fifo_low) nirq[3] = 1;
      if (m_st == 2 && dat_ready && fifo_empty) begin
        if (m_scnt == LIM - 1) begin nirq[4] = 1; m_scnt = 0; end else m_scnt++;
      end else m_scnt = 0;
      if (mx_rej) nirq[5] = 1;
      m_irq = nirq;
      if (m_st == 0 && mx_new) begin
        mc_idx = mp_idx; mc_arg = mp_arg; m_left = mp_bytes; m_fixed = mp_bytes != 0;
        m_auto = mp_auto; m_blk = mp_blk; m_pos = 0; m_st = mx_stopP ? 6 : 1;
      end else if (m_st == 1 && mx_done) m_st = 2;
      else if (m_st == 2 || m_st == 3) begin
        if (mx_stop) begin mc_idx = mp_idx; mc_arg = mp_arg; m_st = 5; end
        else if (mx_xfer) begin
          m_pos = (m_pos == m_blk - 1) ? 0 : m_pos + 1;
          if (m_fixed) begin
            m_left--;
            if (m_left == 0) m_st = m_auto ? 4 : 3;
          end
        end
      end else if (m_st >= 4 && mx_done) m_st = 0;
      if (mx_new || mx_stop || mx_rej) m_pend = 0;
      else if (go && !m_pend) begin
        m_pend = 1; mp_idx = go_idx; mp_arg = go_arg; mp_bytes = go_bytes;
        mp_blk = go_blk; mp_auto = go_auto;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    chk("R1 start_pend", start_pend, m_pend);
    chk("R2 cmd_req", cmd_req, mx_req);
    if (mx_req) begin
      chk("R2/R7 cmd_idx", cmd_idx, (m_st == 4) ? 6'd12 : mc_idx);
      chk("R2/R7 cmd_arg", cmd_arg, (m_st == 4) ? 32'd0 : mc_arg);
    end
    chk("R5/R6/R8/R9 fifo_rd", fifo_rd, mx_xfer);
    chk("R5 dat_last", dat_last, mx_last);
    chk("R2 irq cmd done", irq[0], m_irq[0]);
    chk("R7 irq auto done", irq[1], m_irq[1]);
    chk("R7/R9 irq xfer done", irq[2], m_irq[2]);
    chk("R10 irq data req", irq[3], m_irq[3]);
    chk("R11 irq starve", irq[4], m_irq[4]);
    chk("R4 irq error", irq[5], m_irq[5]);
    chk("R12 irq vector", irq, m_irq);
    chk("R2 resp_main", resp_main, m_resp);
    chk("R7 stop_resp", stop_resp, m_sresp);
    if (cmd_done) begin cmd_done = 0; lat = 0; end
    else if (mx_req) begin
      lat++;
      if (lat == 2) begin
        cmd_done = 1; cmd_resp = 32'hC0DE0000 + rcount; last_resp = cmd_resp; rcount++;
      end
    end
    fifo_empty = (fe_mode == 2) || (fe_mode == 1 && (cyc % 5) == 3);
    fifo_low = fe_mode == 2;
    #1;
    if (fifo_rd) d_pops++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  endtask

  task automatic start(logic [5:0] idx, logic [31:0] arg, int bytes, int blk, bit au);
    go_idx = idx; go_arg = arg; go_bytes = 16'(bytes); go_blk = 16'(blk); go_auto = au; go = 1;
    step();
    go = 0;
  endtask

  task automatic wait_idle(string tag);
    for (int i = 0; i < 2000 && !(m_st == 0 && !m_pend); i++) step();
    n_chk++;
    if (!(m_st == 0 && !m_pend)) begin
      n_fail++; $display("FAIL %s did not return idle actual=%0d expected=0", tag, m_st);
    end
    step();
  endtask

  initial begin
    repeat (3) step();
    chk("R1 reset start_pend", start_pend, 0);
    chk("R12 reset irq", irq, 0);
    chk("R2 reset cmd_req", cmd_req, 0);
    rst_n = 1;
    step();

    // fixed length, auto stop, gappy FIFO
    fe_mode = 1; d_pops = 0;
    start(6'd25, 32'h0000_1000, 32, 8, 1);
    chk("R1 pending after go", start_pend, 1);
    wait_idle("R7");
    chk("R6 pops fixed auto", d_pops, 32);
    chk("R7 stop response", stop_resp, last_resp);
    chk("R7 flags auto+xfer", irq[2:1], 2'b11);

    irq_clr = 6'h3f; step(); irq_clr = 0; step();
    chk("R12 cleared", irq, 0);

    // bad geometry
    fe_mode = 0; d_pops = 0;
    start(6'd25, 32'h2, 30, 8, 1);
    repeat (4) step();
    chk("R4 error flag", irq[5], 1);
    chk("R4 no command", cmd_req, 0);
    chk("R4 no pops", d_pops, 0);

    // fixed length without auto stop
    d_pops = 0;
    start(6'd25, 32'h3, 16, 4, 0);
    for (int i = 0; i < 500 && m_st != 3; i++) step();
    repeat (10) step();
    chk("R8 pops then halt", d_pops, 16);
    chk("R8 no auto flag", irq[1], 0);
    start(6'd12, 32'h0, 0, 0, 0);
    wait_idle("R8");
    chk("R9 sw stop xfer done", irq[2], 1);
    irq_clr = 6'h3f; step(); irq_clr = 0;

    // stop queued behind a command in flight
    d_pops = 0;
    start(6'd25, 32'h4, 64, 16, 1);
    for (int i = 0; i < 50 && m_st != 1; i++) step();
    start(6'd12, 32'h5, 0, 0, 0);
    chk("R3 stop waits during command", start_pend, 1);
    wait_idle("R3");
    chk("R3 stop cut data", d_pops, 0);
    chk("R3 no auto stop", irq[1], 0);
    irq_clr = 6'h3f; step(); irq_clr = 0;

    // open ended, then starvation
    d_pops = 0;
    start(6'd25, 32'h6, 0, 4, 1);
    repeat (40) step();
    chk("R9 open ended keeps popping", (d_pops > 30) ? 1 : 0, 1);
    fe_mode = 2;
    repeat (LIM + 6) step();
    chk("R10 data request", irq[3], 1);
    chk("R11 starvation", irq[4], 1);
    fe_mode = 0;
    start(6'd12, 32'h7, 0, 0, 0);
    wait_idle("R9");
    chk("R9 xfer done", irq[2], 1);

    // lone command from idle
    irq_clr = 6'h3f; step(); irq_clr = 0;
    start(6'd12, 32'h8, 0, 0, 0);
    wait_idle("R2");
    chk("R2 lone response", resp_main, last_resp);
    chk("R2 lone flag only", irq, 6'h01);

    finish_run();
  end
endmodule